// File: doc/BRIEF.md
# Multiplexed Bus Turnaround Controller

This block runs one shared address/data local bus that sits behind an external bidirectional transceiver. A requester offers one read, write or read-modify-write at a time on a valid/ready interface. For each access the block puts the address on the shared lines with a one-cycle address-latch strobe. It then either keeps driving the lines with write data, or it turns the transceiver around and releases the lines so that the external device can return read data. Completion is signalled with a one-cycle acknowledge, which carries the captured read data.

The shared lines can only change owner safely through an idle cycle. A registered flag records whether the controller left the lines at high impedance in the previous cycle. When that flag is set, exactly one turnaround cycle is placed in front of the next address phase: in that cycle the direction pin is already back in the outbound direction, but nothing drives the lines yet. When the controller was already driving, the address follows the request immediately. Data is placed on fixed low lanes according to the port width: 8, 16 or 32 bits.

Top module: `muxBusSeq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, reqReady=1, busOe=1, busDir=1, ale=0 and ack=0. The release flag starts cleared, so the first access after reset begins its address phase in the cycle right after acceptance.
- R2: Each address phase is exactly one cycle with ale=1, busOut equal to the accepted address, busOe=1 and busDir=1 (1 is the outbound, write direction).
- R3: reqOp=1 is a write. Its data phase starts in the cycle after ale and lasts DATA_CYC cycles. During it busOe=1, busDir=1 and busOut equals the write data with the unused lanes forced to zero.
- R4: reqOp=0 (and the unused code 3) is a read. Its data phase starts in the cycle after ale and lasts DATA_CYC cycles, with busDir=0 and busOe=0.
- R5: Read data is captured from busIn on the last read cycle only. ack is a one-cycle pulse that appears in the cycle after the last data cycle, with rdData valid in that cycle.
- R6: When the lines were released in the cycle before an address phase could begin, exactly one cycle with busOe=0 and busDir=1 comes between the release and ale. busDir returns high while busOe is still low.
- R7: No turnaround cycle is inserted when the controller was driving the lines in the previous cycle. Examples are a write after a write, or any access after reset.
- R8: reqOp=2 is a read-modify-write. A read phase is followed by one turnaround cycle, a second address phase with the same address, and a write data phase. A single ack follows the write, and it returns the data read in the read phase.
- R9: Whenever busDir=0 (the device owns the lines), busOe=0.
- R10: reqSize selects the port width: 0 means 8 bits on lanes 0 to 7, 1 means 16 bits on lanes 0 to 15, and 2 or 3 means 32 bits on lanes 0 to 31. Lanes above the width are zero in busOut write data and in rdData.
- R11: After a read completes, the idle bus stays released (busOe=0) with busDir=1 until the next request. After a write completes, the idle bus stays driven (busOe=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqOp | input | 2 | 0 read, 1 write, 2 read-modify-write |
| reqAddr | input | BUS_W | Access address |
| reqWData | input | BUS_W | Write data |
| reqSize | input | 2 | Port width code |
| reqReady | output | 1 | Controller idle, request taken when valid |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | BUS_W | Captured read data, masked to port width |
| busIn | input | BUS_W | Value seen on the shared lines |
| busOut | output | BUS_W | Value driven onto the shared lines |
| busOe | output | 1 | Tri-state enable, 1 = controller drives |
| busDir | output | 1 | Transceiver direction, 1 = outbound |
| ale | output | 1 | Address-latch strobe |

## Verification
Four properties are checked on every cycle:
- there is no contention while the device owns the lines;
- the address strobe lasts one cycle and is held with the outbound, driven setting;
- the direction falls only right after an address phase, and it rises while the lines are still released;
- ack is a single-cycle pulse.

Some behaviours can only be shown by the bench's sweeps over every ordered pair of operations, each port width and idle gaps:
- whether a turnaround cycle is present or absent in front of each address;
- the address and data values;
- lane masking;
- that read data is captured on the last cycle;
- the read-modify-write ordering.

// File: rtl/muxBusPkg.sv
package muxBusPkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_SPARE = 2'd3
  } opE;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_ADDR,
    S_WDATA,
    S_RDATA
  } stateE;

  typedef struct packed {
    logic accept;
    logic driveAddr;
    logic driveData;
    logic capture;
    logic ackSet;
  } strobeT;
endpackage

// File: rtl/muxBusCtrl.sv
module muxBusCtrl
  import muxBusPkg::*;
#(
  parameter int DATA_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output logic       ale,
  output logic       busOe,
  output logic       busDir,
  output strobeT     strobes
);
  localparam int CNT_W = (DATA_CYC < 2) ? 1 : $clog2(DATA_CYC);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(DATA_CYC - 1);

  stateE           state, nextState;
  opE              opQ;
  logic            writePhase;
  logic            relFlag;
  logic [CNT_W-1:0] beat;
  logic            lastBeat;

  assign lastBeat = (beat == LAST_BEAT);

  always_comb begin
    strobes   = '0;
    ale       = 1'b0;
    busOe     = 1'b1;
    busDir    = 1'b1;
    reqReady  = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        busOe    = !relFlag;
        if (reqValid) begin
          strobes.accept = 1'b1;
          nextState      = relFlag ? S_TURN : S_ADDR;
        end
      end
      S_TURN: begin
        busOe     = 1'b0;
        nextState = S_ADDR;
      end
      S_ADDR: begin
        ale               = 1'b1;
        strobes.driveAddr = 1'b1;
        nextState         = writePhase ? S_WDATA : S_RDATA;
      end
      S_RDATA: begin
        busOe  = 1'b0;
        busDir = 1'b0;
        if (lastBeat) begin
          strobes.capture = 1'b1;
          if (opQ == OP_RMW) begin
            nextState = S_TURN;
          end else begin
            nextState      = S_IDLE;
            strobes.ackSet = 1'b1;
          end
        end
      end
      S_WDATA: begin
        strobes.driveData = 1'b1;
        if (lastBeat) begin
          nextState      = S_IDLE;
          strobes.ackSet = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      opQ        <= OP_READ;
      writePhase <= 1'b0;
      relFlag    <= 1'b0;
      beat       <= '0;
    end else begin
      state   <= nextState;
      relFlag <= !busOe;
      if (strobes.accept) begin
        opQ        <= opE'(reqOp);
        writePhase <= (opE'(reqOp) == OP_WRITE);
      end else if (state == S_RDATA && lastBeat && opQ == OP_RMW) begin
        writePhase <= 1'b1;
      end
      if (state == S_ADDR) begin
        beat <= '0;
      end else if (state == S_RDATA || state == S_WDATA) begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/muxBusDatapath.sv
module muxBusDatapath
  import muxBusPkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWData,
  input  logic [1:0]       reqSize,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic [BUS_W-1:0] rdData,
  output logic             ack
);
  logic [BUS_W-1:0] addrQ, wdataQ, laneMask;
  logic [1:0]       sizeQ;
  int               portBits;

  always_comb begin
    case (sizeQ)
      2'd0:    portBits = 8;
      2'd1:    portBits = 16;
      default: portBits = 32;
    endcase
    for (int i = 0; i < BUS_W; i++) begin
      laneMask[i] = (i < portBits);
    end
  end

  always_comb begin
    if (strobes.driveAddr)      busOut = addrQ;
    else if (strobes.driveData) busOut = wdataQ & laneMask;
    else                        busOut = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      sizeQ  <= 2'd2;
      rdData <= '0;
      ack    <= 1'b0;
    end else begin
      ack <= strobes.ackSet;
      if (strobes.accept) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWData;
        sizeQ  <= reqSize;
      end
      if (strobes.capture) begin
        rdData <= busIn & laneMask;
      end
    end
  end
endmodule

// File: rtl/muxBusSeq.sv
module muxBusSeq
  import muxBusPkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int DATA_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWData,
  input  logic [1:0]       reqSize,
  output logic             reqReady,
  output logic             ack,
  output logic [BUS_W-1:0] rdData,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic             busDir,
  output logic             ale
);
  strobeT strobes;

  muxBusCtrl #(.DATA_CYC(DATA_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .ale(ale), .busOe(busOe), .busDir(busDir),
    .strobes(strobes)
  );

  muxBusDatapath #(.BUS_W(BUS_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWData(reqWData), .reqSize(reqSize), .busIn(busIn),
    .busOut(busOut), .rdData(rdData), .ack(ack)
  );
endmodule

// File: rtl/muxBusChecker.sv
module muxBusChecker (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic busOe,
  input logic busDir,
  input logic ack
);
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !busDir |-> !busOe); // R9
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R2
  AST_ALE_DRIVEN_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (busOe && busDir)); // R2
  AST_DIR_LOW_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busDir) |-> $past(ale)); // R4
  AST_DIR_RISES_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDir) |-> !busOe); // R6
  AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> $past(busDir)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack); // R5
endmodule

bind muxBusSeq muxBusChecker i_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .busOe(busOe), .busDir(busDir), .ack(ack)
);

// File: tb/test_muxBusSeq.sv
module test_muxBusSeq;
  localparam int BUS_W    = 32;
  localparam int DATA_CYC = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [1:0]       reqOp = 2'd0;
  logic [BUS_W-1:0] reqAddr = '0;
  logic [BUS_W-1:0] reqWData = '0;
  logic [1:0]       reqSize = 2'd0;
  logic             reqReady, ack, busOe, busDir, ale;
  logic [BUS_W-1:0] rdData, busOut;
  logic [BUS_W-1:0] busIn = '0;

  int  testCount = 0;
  int  failCount = 0;
  logic lastEndRead = 1'b0;

  always #2 clk = !clk;

  muxBusSeq #(.BUS_W(BUS_W), .DATA_CYC(DATA_CYC)) i_muxBusSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqSize(reqSize),
    .reqReady(reqReady), .ack(ack), .rdData(rdData), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .busDir(busDir), .ale(ale)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskOf(input int sz);
    if (sz == 0) return 32'h0000_00FF;
    if (sz == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic doOp(input int op, input int sz, input int gap,
                      input logic [31:0] a, input logic [31:0] wd, input logic [31:0] dev);
    int aleCnt, rdCnt, wrCnt, relRun, cycles;
    logic prevData, done, expTurn;
    logic [31:0] m;
    aleCnt = 0; rdCnt = 0; wrCnt = 0; relRun = 0; cycles = 0;
    prevData = 1'b0; done = 1'b0; m = maskOf(sz);
    repeat (gap) @(negedge clk);
    check(reqReady == 1'b1, "R1 ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqOp = 2'(op); reqSize = 2'(sz); reqAddr = a; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && cycles < 60) begin
      cycles++;
      if (ack) begin
        done = 1'b1;
        check(prevData, "R5 ack right after last data cycle", 32'(prevData), 32'd1);
        if (op != 1) check(rdData == (dev & m), "R5/R10 read data", rdData, dev & m);
        if (op == 0) check(!busOe && busDir, "R11 idle released after read", {busOe, busDir}, 32'b01);
        else         check(busOe && busDir, "R11 idle driven after write", {busOe, busDir}, 32'b11);
      end else begin
        if (ale) begin
          aleCnt++;
          expTurn = (aleCnt == 1) ? lastEndRead : 1'b1;
          check(relRun == int'(expTurn), "R6/R7/R8 turnaround count", 32'(relRun), 32'(expTurn));
          check(busOut == a, "R2 address on lines", busOut, a);
          check(busOe && busDir, "R2 address driven outbound", {busOe, busDir}, 32'b11);
          prevData = 1'b0; relRun = 0;
        end else if (!busDir) begin
          check(!busOe, "R9 released while device drives", 32'(busOe), 32'd0);
          rdCnt++;
          busIn = (rdCnt == DATA_CYC) ? dev : ~dev;
          prevData = 1'b1; relRun = 0;
        end else if (!busOe) begin
          relRun++; prevData = 1'b0;
        end else begin
          wrCnt++;
          check(busOut == (wd & m), "R3/R10 write data lanes", busOut, wd & m);
          prevData = 1'b1; relRun = 0;
        end
        @(negedge clk);
      end
    end
    check(done, "R5 ack seen", 32'(done), 32'd1);
    check(aleCnt == ((op == 2) ? 2 : 1), "R2/R8 address phases", 32'(aleCnt), (op == 2) ? 32'd2 : 32'd1);
    check(rdCnt == ((op == 1) ? 0 : DATA_CYC), "R4 read cycles", 32'(rdCnt), (op == 1) ? 32'd0 : 32'(DATA_CYC));
    check(wrCnt == ((op == 0) ? 0 : DATA_CYC), "R3 write cycles", 32'(wrCnt), (op == 0) ? 32'd0 : 32'(DATA_CYC));
    lastEndRead = (op == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && busOe && busDir && !ale && !ack, "R1 reset outputs",
          {reqReady, busOe, busDir, ale, ack}, 32'b11100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && busOe && busDir && !ale && !ack, "R1 idle after reset",
          {reqReady, busOe, busDir, ale, ack}, 32'b11100);
    doOp(1, 2, 0, 32'hA000_0004, 32'h1122_3344, 32'h0);
    for (int p = 0; p < 3; p++) begin
      for (int o = 0; o < 3; o++) begin
        for (int s = 0; s < 4; s++) begin
          logic [31:0] k;
          k = 32'(p * 16 + o * 4 + s);
          doOp(p, s, (s == 1) ? 2 : 0, 32'h1000_0000 + k * 32'h0101,
               32'hC3A5_5A3C ^ (k << 8), 32'h8765_4321 + k * 32'h1111);
          doOp(o, s, 0, 32'h2000_0000 + k * 32'h0303,
               32'h5A5A_F00F ^ k, 32'hDEAD_0000 | k);
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule